// File: doc/BRIEF.md
# Byte-Memory DMA Engine

This engine copies blocks of words between an 8-bit wide external byte memory and on-chip word memory. It works in either direction. An on-chip destination is a 24-bit program-memory word made from three bytes, or a 16-bit data-memory word made from two bytes. Bytes are taken or emitted most-significant first. Software sets the direction, word type, wait states, hold-off mode and both start addresses. It then writes a nonzero word count, and that write launches the transfer. The engine runs byte accesses with the chosen number of wait states. It packs or unpacks the bytes and moves each complete word across the on-chip port in one cycle.

External-bus requests from the processor win over the engine. A byte access never begins while such a request is active. An access that has already begun runs to its end. In hold-off mode the processor is stalled for the whole transfer. At completion the engine emits a restart pulse that tells the core to clear its context and resume at address 0. The byte memory and the processor are represented by simple handshake ports.

Top module: `bytemem_dma`

## Requirements
- R1: When idle, a write of a nonzero value to the word count starts a transfer, and `busy` rises in the next cycle. A write of zero has no effect. A count write while a transfer is running is ignored, and the running transfer keeps its original count.
- R2: Each byte access holds `bm_en` high for exactly `cfg_waits`+1 consecutive cycles. `bm_addr` is held steady throughout, and `bm_strobe` is high only in the final cycle. Read data is captured, and write data is taken, at the end of that final cycle.
- R3: Each on-chip word moves in a single cycle with `mem_req` high. On a load it is written after its last byte. On a store it is read before its first byte.
- R4: While `cpu_ext_req` is high, no new byte access begins. The first access after the request drops begins in the following cycle.
- R5: With `cfg_ctx_reset`=0, `cpu_hold` and `cpu_restart` remain 0 for the whole transfer.
- R6: With `cfg_ctx_reset`=1, `cpu_hold` is high in every busy cycle. `cpu_restart` pulses for one cycle together with `done_pulse`.
- R7: `cfg_type`=0 selects program memory, where each word is three bytes packed MSB first into 24 bits. `cfg_type`=1 selects data memory, where each word is two bytes packed MSB first into bits 15:0 with bits 23:16 zero.
- R8: `cfg_dir`=0 loads from byte memory into on-chip memory. `cfg_dir`=1 stores on-chip words into byte memory.
- R9: The external address starts at `cfg_ext_addr` and rises by one after each byte. The on-chip address starts at `cfg_int_addr` and rises by one after each word. No location outside the range is touched.
- R10: For n words of b bytes with w wait states, the transfer occupies n*(b*(w+2)+1) busy cycles when not blocked. `done_pulse` is high for one cycle right after the last busy cycle. `done` is set then and stays set until the next start clears it.
- R11: After reset the engine is idle, with `busy`, `done`, `bm_en`, `mem_req` and `cpu_hold` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_we | input | 1 | Word-count write strobe |
| cnt_wdata | input | CNT_W | Word count to write |
| cfg_dir | input | 1 | 0 load from byte memory, 1 store to byte memory |
| cfg_type | input | 1 | 0 program-memory 24-bit words, 1 data-memory 16-bit words |
| cfg_ctx_reset | input | 1 | 1 stalls the processor and restarts it at completion |
| cfg_waits | input | WAIT_W | Wait states per byte access |
| cfg_int_addr | input | INT_AW | Start on-chip word address |
| cfg_ext_addr | input | EXT_AW | Start byte-memory address |
| cpu_ext_req | input | 1 | Processor external-bus request (priority) |
| bm_en | output | 1 | Byte access in progress |
| bm_we | output | 1 | Byte access is a write |
| bm_strobe | output | 1 | Final cycle of the byte access |
| bm_addr | output | EXT_AW | Byte-memory address |
| bm_wdata | output | 8 | Byte written |
| bm_rdata | input | 8 | Byte read |
| mem_req | output | 1 | On-chip word transfer cycle |
| mem_we | output | 1 | On-chip transfer is a write |
| mem_pm | output | 1 | On-chip transfer targets program memory |
| mem_addr | output | INT_AW | On-chip word address |
| mem_wdata | output | 24 | On-chip write word |
| mem_rdata | input | 24 | On-chip read word (valid in the same cycle) |
| cpu_hold | output | 1 | Processor stall |
| cpu_restart | output | 1 | Clear context and restart at address 0 |
| busy | output | 1 | Transfer running |
| done | output | 1 | Last transfer finished |
| done_pulse | output | 1 | One-cycle completion pulse |

## Verification
A transfer starts on the edge that samples the count write. `busy` and the hold are due one cycle later. Each byte then costs one arbitration cycle plus wait states+1 access cycles, and each word adds one transfer cycle. `done_pulse` and `cpu_restart` are due in cycle n*(b*(w+2)+1)+1, counted from that edge. The bench drives on falling edges and counts falling edges from the start. The completion cycle, the hold cycles and the length of every `bm_en` run are therefore compared with figures computed from that formula. A processor block adds its own length in cycles. Memory contents are compared after the completion cycle.

// File: rtl/bdma_pkg.sv
// Shared constants and the controller state type for the byte-memory DMA engine.
package bdma_pkg;
    localparam int BYTE_W = 8;
    localparam int PM_W   = 24;
    localparam int DM_W   = 16;
    localparam int PM_BYTES = PM_W / BYTE_W;
    localparam int DM_BYTES = DM_W / BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,   // arbitration cycle before each byte access
        ST_BYTE = 2'd2,   // byte access including wait states
        ST_WORD = 2'd3    // single-cycle on-chip word transfer
    } bdma_state_t;
endpackage

// File: rtl/bdma_wait_timer.sv
// Wait-state timer: counts the cycles of one byte access.
// Assumes: load is pulsed in the cycle before the access begins; active is
// high for every cycle of the access. last flags the final access cycle.
module bdma_wait_timer #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] waits,
    input  logic              active,
    output logic              last
);
    logic [WAIT_W-1:0] wcnt;

    // Reload at access start, count down while the access runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wcnt <= '0;
        else if (load)
            wcnt <= waits;
        else if (active && wcnt != '0)
            wcnt <= wcnt - WAIT_W'(1);
    end

    assign last = active && (wcnt == '0);

    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (wcnt <= waits)); // R2
endmodule

// File: rtl/bdma_packer.sv
// Byte packer / unpacker: assembles bytes into a word MSB first (load) or
// splits a word into bytes MSB first (store).
// Assumes: data-memory words sit in the low DM_W bits of the word bus.
module bdma_packer
    import bdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pm,
    input  logic              cap_byte,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              load_word,
    input  logic [PM_W-1:0]   word_in,
    input  logic              shift_out,
    output logic [PM_W-1:0]   word_out,
    output logic [BYTE_W-1:0] byte_out
);
    logic [PM_W-1:0] sh;

    // Shift register shared by both directions.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh <= '0;
        else if (load_word)
            sh <= pm ? word_in : {word_in[DM_W-1:0], {(PM_W-DM_W){1'b0}}};
        else if (cap_byte)
            sh <= {sh[PM_W-BYTE_W-1:0], byte_in};
        else if (shift_out)
            sh <= {sh[PM_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
    end

    // Word view: program words use all bits, data words are zero-extended.
    always_comb begin
        if (pm)
            word_out = sh;
        else
            word_out = {{(PM_W-DM_W){1'b0}}, sh[DM_W-1:0]};
    end

    assign byte_out = sh[PM_W-1 -: BYTE_W];
endmodule

// File: rtl/bdma_ctrl.sv
// Transfer controller: latches the setup on a nonzero count write, sequences
// arbitration, byte accesses and word transfers, keeps the counters and the
// addresses, and produces completion and processor hold-off signals.
// Assumes: byte_last comes from the wait timer; cpu_ext_req may change at any cycle.
module bdma_ctrl
    import bdma_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int WAIT_W = 3,
    parameter int INT_AW = 14,
    parameter int EXT_AW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              cfg_dir,
    input  logic              cfg_type,
    input  logic              cfg_ctx_reset,
    input  logic [WAIT_W-1:0] cfg_waits,
    input  logic [INT_AW-1:0] cfg_int_addr,
    input  logic [EXT_AW-1:0] cfg_ext_addr,
    input  logic              cpu_ext_req,
    input  logic              byte_last,
    output logic              byte_go,
    output logic              in_byte,
    output logic              in_word,
    output logic              dir_q,
    output logic              pm_q,
    output logic [WAIT_W-1:0] waits_q,
    output logic [INT_AW-1:0] iaddr_q,
    output logic [EXT_AW-1:0] eaddr_q,
    output logic              busy,
    output logic              done,
    output logic              done_pulse,
    output logic              cpu_hold,
    output logic              cpu_restart
);
    bdma_state_t     state;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       bidx;
    logic             ctx_q;
    logic             last_byte_of_word;

    assign last_byte_of_word = pm_q ? (bidx == 2'(PM_BYTES-1)) : (bidx == 2'(DM_BYTES-1));
    assign byte_go  = (state == ST_GAP) && !cpu_ext_req;
    assign in_byte  = (state == ST_BYTE);
    assign in_word  = (state == ST_WORD);
    assign busy     = (state != ST_IDLE);
    assign cpu_hold = busy && ctx_q;

    // Sequencer with setup latch, count, addresses and completion flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cnt_q       <= '0;
            bidx        <= '0;
            dir_q       <= 1'b0;
            pm_q        <= 1'b1;
            ctx_q       <= 1'b0;
            waits_q     <= '0;
            iaddr_q     <= '0;
            eaddr_q     <= '0;
            done        <= 1'b0;
            done_pulse  <= 1'b0;
            cpu_restart <= 1'b0;
        end else begin
            done_pulse  <= 1'b0;
            cpu_restart <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cnt_we && cnt_wdata != '0) begin
                        cnt_q   <= cnt_wdata;
                        dir_q   <= cfg_dir;
                        pm_q    <= !cfg_type;
                        ctx_q   <= cfg_ctx_reset;
                        waits_q <= cfg_waits;
                        iaddr_q <= cfg_int_addr;
                        eaddr_q <= cfg_ext_addr;
                        bidx    <= '0;
                        done    <= 1'b0;
                        state   <= cfg_dir ? ST_WORD : ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (!cpu_ext_req)
                        state <= ST_BYTE;
                end
                ST_BYTE: begin
                    if (byte_last) begin
                        eaddr_q <= eaddr_q + EXT_AW'(1);
                        if (!last_byte_of_word) begin
                            bidx  <= bidx + 2'd1;
                            state <= ST_GAP;
                        end else begin
                            bidx <= '0;
                            if (!dir_q) begin
                                state <= ST_WORD;
                            end else if (cnt_q == CNT_W'(1)) begin
                                cnt_q       <= '0;
                                state       <= ST_IDLE;
                                done        <= 1'b1;
                                done_pulse  <= 1'b1;
                                cpu_restart <= ctx_q;
                            end else begin
                                cnt_q <= cnt_q - CNT_W'(1);
                                state <= ST_WORD;
                            end
                        end
                    end
                end
                ST_WORD: begin
                    iaddr_q <= iaddr_q + INT_AW'(1);
                    if (dir_q) begin
                        state <= ST_GAP;
                    end else if (cnt_q == CNT_W'(1)) begin
                        cnt_q       <= '0;
                        state       <= ST_IDLE;
                        done        <= 1'b1;
                        done_pulse  <= 1'b1;
                        cpu_restart <= ctx_q;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                        state <= ST_GAP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0)); // R1
    AST_CPU_BLOCKS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP && cpu_ext_req) |=> (state == ST_GAP)); // R4
    AST_DONE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R10
    AST_RESTART_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_restart |-> ($past(cpu_hold) && done_pulse)); // R6
endmodule

// File: rtl/bytemem_dma.sv
// Byte-memory DMA engine top: wires the controller, the wait-state timer and
// the byte packer onto the byte-memory, on-chip memory and processor ports.
// Assumes: mem_rdata is valid in the cycle mem_req is high; bm_rdata is valid
// in the final cycle of a byte access.
module bytemem_dma
    import bdma_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int WAIT_W = 3,
    parameter int INT_AW = 14,
    parameter int EXT_AW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              cfg_dir,
    input  logic              cfg_type,
    input  logic              cfg_ctx_reset,
    input  logic [WAIT_W-1:0] cfg_waits,
    input  logic [INT_AW-1:0] cfg_int_addr,
    input  logic [EXT_AW-1:0] cfg_ext_addr,
    input  logic              cpu_ext_req,
    output logic              bm_en,
    output logic              bm_we,
    output logic              bm_strobe,
    output logic [EXT_AW-1:0] bm_addr,
    output logic [7:0]        bm_wdata,
    input  logic [7:0]        bm_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_pm,
    output logic [INT_AW-1:0] mem_addr,
    output logic [23:0]       mem_wdata,
    input  logic [23:0]       mem_rdata,
    output logic              cpu_hold,
    output logic              cpu_restart,
    output logic              busy,
    output logic              done,
    output logic              done_pulse
);
    logic              byte_go, in_byte, in_word, dir_q, pm_q, byte_last;
    logic [WAIT_W-1:0] waits_q;

    bdma_ctrl #(
        .CNT_W(CNT_W), .WAIT_W(WAIT_W), .INT_AW(INT_AW), .EXT_AW(EXT_AW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cfg_dir(cfg_dir), .cfg_type(cfg_type), .cfg_ctx_reset(cfg_ctx_reset),
        .cfg_waits(cfg_waits), .cfg_int_addr(cfg_int_addr), .cfg_ext_addr(cfg_ext_addr),
        .cpu_ext_req(cpu_ext_req), .byte_last(byte_last),
        .byte_go(byte_go), .in_byte(in_byte), .in_word(in_word),
        .dir_q(dir_q), .pm_q(pm_q), .waits_q(waits_q),
        .iaddr_q(mem_addr), .eaddr_q(bm_addr),
        .busy(busy), .done(done), .done_pulse(done_pulse),
        .cpu_hold(cpu_hold), .cpu_restart(cpu_restart)
    );

    bdma_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(byte_go), .waits(waits_q), .active(in_byte), .last(byte_last)
    );

    bdma_packer u_pack (
        .clk(clk), .rst_n(rst_n), .pm(pm_q),
        .cap_byte(byte_last && !dir_q), .byte_in(bm_rdata),
        .load_word(in_word && dir_q), .word_in(mem_rdata),
        .shift_out(byte_last && dir_q),
        .word_out(mem_wdata), .byte_out(bm_wdata)
    );

    assign bm_en     = in_byte;
    assign bm_we     = in_byte && dir_q;
    assign bm_strobe = byte_last;
    assign mem_req   = in_word;
    assign mem_we    = in_word && !dir_q;
    assign mem_pm    = pm_q;

    AST_ACCESS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_en && !bm_strobe) |=> (bm_en && $stable(bm_addr))); // R2
    AST_WORD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R3
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && bm_en)); // R3
endmodule

// File: tb/tb_bytemem_dma.sv
module tb_bytemem_dma;
    typedef struct packed {
        logic       dir;
        logic       typ;
        logic       ctx;
        logic [2:0] waits;
        logic [3:0] words;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b1, 3'd0, 4'd2},
        '{1'b0, 1'b1, 1'b0, 3'd2, 4'd3},
        '{1'b1, 1'b0, 1'b0, 3'd1, 4'd2},
        '{1'b1, 1'b1, 1'b1, 3'd0, 4'd4},
        '{1'b0, 1'b0, 1'b0, 3'd7, 4'd1},
        '{1'b1, 1'b0, 1'b1, 3'd3, 4'd1}
    };

    logic clk = 0, rst_n = 0;
    logic cnt_we = 0, cfg_dir = 0, cfg_type = 0, cfg_ctx = 0, cpu_ext_req = 0;
    logic [13:0] cnt_wdata = '0, cfg_int_addr = '0, cfg_ext_addr = '0;
    logic [2:0]  cfg_waits = '0;
    logic bm_en, bm_we, bm_strobe, mem_req, mem_we, mem_pm;
    logic cpu_hold, cpu_restart, busy, done, done_pulse;
    logic [13:0] bm_addr, mem_addr;
    logic [7:0]  bm_wdata, bm_rdata;
    logic [23:0] mem_wdata, mem_rdata;

    logic [7:0]  bmem [256];
    logic [23:0] wmem [64];
    logic [7:0]  bmem0 [256];
    logic [23:0] wmem0 [64];
    logic fill_req = 0;
    logic [7:0] fill_seed = '0;

    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    bytemem_dma dut (
        .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cfg_dir(cfg_dir), .cfg_type(cfg_type), .cfg_ctx_reset(cfg_ctx),
        .cfg_waits(cfg_waits), .cfg_int_addr(cfg_int_addr), .cfg_ext_addr(cfg_ext_addr),
        .cpu_ext_req(cpu_ext_req),
        .bm_en(bm_en), .bm_we(bm_we), .bm_strobe(bm_strobe), .bm_addr(bm_addr),
        .bm_wdata(bm_wdata), .bm_rdata(bm_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_pm(mem_pm), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cpu_hold(cpu_hold), .cpu_restart(cpu_restart),
        .busy(busy), .done(done), .done_pulse(done_pulse)
    );

    assign bm_rdata  = bmem[bm_addr[7:0]];
    assign mem_rdata = wmem[mem_addr[5:0]];

    // Memory models: pattern fill on request, otherwise accept writes.
    always @(posedge clk) begin
        if (fill_req) begin
            for (int i = 0; i < 256; i++) bmem[i] <= 8'(i * 29 + 7) ^ fill_seed;
            for (int i = 0; i < 64; i++)  wmem[i] <= 24'(i * 24'h0B1C35) ^ {3{fill_seed}};
        end else begin
            if (bm_strobe && bm_we) bmem[bm_addr[7:0]] <= bm_wdata;
            if (mem_req && mem_we)  wmem[mem_addr[5:0]] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] s);
        @(negedge clk); fill_req = 1; fill_seed = s;
        @(negedge clk); fill_req = 0;
        bmem0 = bmem;
        wmem0 = wmem;
    endtask

    // One transfer; blk = cycles cpu_ext_req is held from start, poke = cycle
    // of a count write during the run (0 = none).
    task automatic run(input vec_t v, input int ib, input int eb, input int blk,
                       input int poke, input string tag);
        int nb, n_exp, k, holds, rsts, runlen, badrun, enblk, mism, first_a, first_e;
        nb = v.typ ? 2 : 3;
        n_exp = int'(v.words) * (nb * (int'(v.waits) + 2) + 1);
        if (blk > 0) n_exp += v.dir ? blk - 1 : blk;
        fill(8'(ib * 7 + eb));
        @(negedge clk);
        cfg_dir = v.dir; cfg_type = v.typ; cfg_ctx = v.ctx; cfg_waits = v.waits;
        cfg_int_addr = 14'(ib); cfg_ext_addr = 14'(eb);
        cnt_wdata = 14'(v.words); cnt_we = 1;
        cpu_ext_req = (blk > 0);
        @(negedge clk);
        cnt_we = 0;
        k = 1; holds = 0; rsts = 0; runlen = 0; badrun = 0; enblk = 0;
        chk(busy === 1'b1, {"R1 busy after start ", tag}, busy, 1);
        chk(done === 1'b0, {"R10 done cleared at start ", tag}, done, 0);
        while (done_pulse !== 1'b1 && k < 4000) begin
            if (blk > 0 && k == blk + 1) cpu_ext_req = 0;
            if (poke > 0 && k == poke) begin cnt_we = 1; cnt_wdata = 14'd9; end
            if (poke > 0 && k == poke + 1) cnt_we = 0;
            if (cpu_hold) holds++;
            if (cpu_restart) rsts++;
            if (cpu_ext_req && bm_en) enblk++;
            if (bm_en) runlen++;
            else if (runlen > 0) begin
                if (runlen != int'(v.waits) + 1) badrun++;
                runlen = 0;
            end
            @(negedge clk); k++;
        end
        cnt_we = 0;
        if (runlen > 0 && runlen != int'(v.waits) + 1) badrun++;
        chk(k == n_exp + 1, {"R10 completion cycle ", tag}, k, n_exp + 1);
        chk(done === 1'b1 && busy === 1'b0, {"R10 done flag ", tag}, done, 1);
        chk(badrun == 0, {"R2 wait-state run length ", tag}, badrun, 0);
        chk(holds == (v.ctx ? n_exp : 0), {v.ctx ? "R6" : "R5", " hold cycles ", tag},
            holds, v.ctx ? n_exp : 0);
        chk(cpu_restart === v.ctx && rsts == 0, {v.ctx ? "R6" : "R5", " restart pulse ", tag},
            cpu_restart, v.ctx);
        if (blk > 0) chk(enblk == 0, {"R4 no access under cpu request ", tag}, enblk, 0);
        @(negedge clk);
        chk(done_pulse === 1'b0 && done === 1'b1, {"R10 pulse one cycle ", tag}, done_pulse, 0);
        mism = 0; first_a = 0; first_e = 0;
        for (int i = 0; i < int'(v.words); i++) begin
            for (int j = 0; j < nb; j++) begin
                logic [7:0] eb_byte;
                logic [23:0] w;
                if (!v.dir) begin
                    w = wmem[ib + i];
                    eb_byte = bmem0[eb + i * nb + j];
                    if (w[8 * (nb - 1 - j) +: 8] !== eb_byte) begin
                        if (mism == 0) begin first_a = w[8 * (nb - 1 - j) +: 8]; first_e = eb_byte; end
                        mism++;
                    end
                end else begin
                    w = wmem0[ib + i];
                    if (bmem[eb + i * nb + j] !== w[8 * (nb - 1 - j) +: 8]) begin
                        if (mism == 0) begin first_a = bmem[eb + i * nb + j]; first_e = w[8 * (nb - 1 - j) +: 8]; end
                        mism++;
                    end
                end
            end
            if (!v.dir && v.typ && wmem[ib + i][23:16] !== 8'h00) mism++;
        end
        chk(mism == 0, {v.dir ? "R8 R7 store bytes MSB first " : "R8 R7 load word packing ", tag},
            first_a, first_e);
        if (!v.dir)
            chk(wmem[ib + int'(v.words)] === wmem0[ib + int'(v.words)] && wmem[ib - 1] === wmem0[ib - 1],
                {"R9 on-chip range bounds ", tag}, wmem[ib + int'(v.words)], wmem0[ib + int'(v.words)]);
        else
            chk(bmem[eb + nb * int'(v.words)] === bmem0[eb + nb * int'(v.words)] && bmem[eb - 1] === bmem0[eb - 1],
                {"R9 byte range bounds ", tag}, bmem[eb + nb * int'(v.words)], bmem0[eb + nb * int'(v.words)]);
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        chk(busy === 0 && done === 0, "R11 reset busy/done", busy, 0);
        chk(bm_en === 0 && mem_req === 0 && cpu_hold === 0, "R11 reset ports idle", bm_en, 0);

        // R1: zero count has no effect
        cnt_wdata = '0; cnt_we = 1;
        @(negedge clk); cnt_we = 0;
        repeat (2) @(negedge clk);
        chk(busy === 0 && bm_en === 0 && done === 0, "R1 zero count ignored", busy, 0);

        for (int n = 0; n < NV; n++)
            run(VEC[n], 8 + n * 5, 20 + n * 16, 0, 0, $sformatf("vec%0d", n));

        // R4: processor request blocks the first byte access for 6 cycles
        run('{1'b0, 1'b1, 1'b0, 3'd1, 4'd1}, 50, 200, 6, 0, "cpu-block");
        // R1: count written mid-transfer is ignored (completion and bounds unchanged)
        run('{1'b0, 1'b0, 1'b1, 3'd0, 4'd2}, 40, 150, 0, 4, "busy-write");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule